// File: doc/BRIEF.md
# Codec Bit-Clock Activity Detector

This block decides whether an external codec is already driving the bit clock of a shared audio link. It also chooses which signalling mode the link uses. In the legacy mode the bit-clock pin is an input. The block passes that pin through a synchronizer into the system clock domain and watches it for transitions. In the newer mode the controller drives the pin itself, using a clock divided down from the system clock.

Software works through one 8-bit control register on a simple write strobe / read data bus. The register has these fields:

| Bit | Field | Access | Meaning |
|-----|-------|--------|---------|
| 0 | mode | R/W | 0 = legacy mode, pin is an input; 1 = newer mode, controller drives the pin |
| 1 | absent flag | read-only | 0 = clock seen toggling; 1 = no clock seen |
| 2 | arm | R/W | 1 = detection runs |
| 3 | wipe | R/W | 1 = forces the absent flag to 1 and holds it there |
| 7:4 | reserved | — | read 0, writes ignored |

Writing arm back to 0 freezes whatever result the flag holds at that moment. The mode bit is cleared only by the power-on reset, so an ordinary reset cannot turn the pin driver on or off under a running codec.

A detection state machine produces the flag. Its states and transitions are:

| State | Meaning | Leaves for |
|-------|---------|------------|
| ST_CLEARED | Wipe is held. | ST_ARMED once wipe drops and arm is 1; ST_IDLE once wipe drops and arm is 0 |
| ST_IDLE | Waiting. Entered from ST_CLEARED, and the state after reset. | ST_ARMED when arm is 1 |
| ST_ARMED | Armed, no transition counted yet. | ST_ONE_EDGE on a counted transition |
| ST_ONE_EDGE | One transition counted. | ST_FOUND on a second counted transition, which also drives the flag to 0 |
| ST_FOUND | Clock seen toggling. | — |
| ST_FROZEN | Result frozen after arm was written to 0. | ST_ARMED when arm is set again |

Two further transitions apply across states:
- Any state goes to ST_CLEARED whenever wipe is 1.
- ST_ARMED, ST_ONE_EDGE and ST_FOUND go to ST_FROZEN when arm is 0.

Top module: `bclk_sense_top`

## Requirements
- R1: After power-on reset the register reads 0x00, `bclk_oe` is 0 and `bclk_out` is 0.
- R2: Writing the register with bit 3 (wipe) set makes bit 1 (absent flag) read 1 from the second clock after the write. The flag stays 1 while wipe is 1, even when the bit clock toggles and bit 2 (arm) is 1.
- R3: With wipe and arm both 0, transitions on `bclk_in` leave the flag unchanged.
- R4: With wipe 0, arm 1 and mode 0, a single transition of `bclk_in` leaves the flag at 1, and a second transition drives it to 0. Each transition is counted three clocks after the pin changes: two synchronizer flops plus one edge flop.
- R5: Writing arm to 0 freezes the flag, and later transitions do not change it. Writing arm to 1 again restarts the count from zero transitions.
- R6: An arm-to-0 write that reaches the state machine in the same cycle as the completing transition freezes the pre-transition value (1). A wipe that arrives in that cycle beats the detection.
- R7: While bit 0 (mode) is 1, transitions on `bclk_in` are not counted.
- R8: `bclk_oe` equals the mode bit. In mode 1, `bclk_out` toggles every DIV_HALF system clocks (default 4). In mode 0 it is held at 0.
- R9: The ordinary reset `rst_n` clears wipe, arm and the flag but keeps the mode bit. `por_n` clears everything.
- R10: Bits 7:4 read 0 and ignore writes. Writes to bit 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, clears all state including mode |
| rst_n | input | 1 | Ordinary reset, active low, keeps mode |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| bclk_in | input | 1 | Bit-clock pin input (asynchronous) |
| bclk_out | output | 1 | Bit clock driven in mode 1 |
| bclk_oe | output | 1 | Bit-clock pin output enable |

## Verification
Register writes and synchronized pin transitions reach the state machine through separate register paths. This means a software write and the completing second transition can land in the same state-machine cycle. The bench provokes this by flipping `bclk_in` and then issuing the write exactly one clock later, so that both reach the state machine at the same edge. When the write clears arm, the bench expects the frozen flag to read 1. It then repeats the sequence with the write one clock later still and expects 0, which shows the collision window is exactly one cycle. A third run puts wipe into the same slot and expects the flag to stay 1.

// File: rtl/bclk_det_pkg.sv
package bclk_det_pkg;

    localparam int CTRL_W   = 8;
    localparam int BIT_MODE = 0;
    localparam int BIT_FLAG = 1;
    localparam int BIT_ARM  = 2;
    localparam int BIT_WIPE = 3;

    typedef enum logic [2:0] {
        ST_CLEARED,
        ST_IDLE,
        ST_ARMED,
        ST_ONE_EDGE,
        ST_FOUND,
        ST_FROZEN
    } det_state_t;

endpackage

// File: rtl/bclk_sync.sv
module bclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic edge_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= 1'b0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign edge_o = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/bclk_clkgen.sv
module bclk_clkgen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    output logic bclk_o
);

    localparam int CNT_W = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bclk_o <= 1'b0;
        end else if (!mode_i) begin
            cnt_q  <= '0;
            bclk_o <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            bclk_o <= ~bclk_o;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R8: driven clock is parked low outside the driving mode
    a_r8_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> !bclk_o);

endmodule

// File: rtl/bclk_ctrl_reg.sv
module bclk_ctrl_reg
    import bclk_det_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              flag_n_i,
    output logic              wipe_o,
    output logic              arm_o,
    output logic              mode_o,
    output logic [CTRL_W-1:0] rdata_o
);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)    mode_o <= 1'b0;
        else if (wr_i) mode_o <= wdata_i[BIT_MODE];
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            wipe_o <= 1'b0;
            arm_o  <= 1'b0;
        end else if (wr_i) begin
            wipe_o <= wdata_i[BIT_WIPE];
            arm_o  <= wdata_i[BIT_ARM];
        end
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[BIT_MODE] = mode_o;
        rdata_o[BIT_FLAG] = flag_n_i;
        rdata_o[BIT_ARM]  = arm_o;
        rdata_o[BIT_WIPE] = wipe_o;
    end

    // R9: only a write or power-on reset may move the mode bit
    a_r9_mode_kept: assert property (@(posedge clk) disable iff (!por_n)
        !wr_i |=> $stable(mode_o));

endmodule

// File: rtl/bclk_det_fsm.sv
module bclk_det_fsm
    import bclk_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wipe_i,
    input  logic arm_i,
    input  logic mode_i,
    input  logic edge_i,
    output logic flag_n_o
);

    det_state_t state_q, state_d;
    logic       hit;

    assign hit = edge_i && !mode_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wipe_i) begin
            state_d = ST_CLEARED;
        end else begin
            unique case (state_q)
                ST_CLEARED:  state_d = arm_i ? ST_ARMED : ST_IDLE;
                ST_IDLE:     state_d = arm_i ? ST_ARMED : ST_IDLE;
                ST_ARMED:    state_d = !arm_i ? ST_FROZEN : (hit ? ST_ONE_EDGE : ST_ARMED);
                ST_ONE_EDGE: state_d = !arm_i ? ST_FROZEN : (hit ? ST_FOUND : ST_ONE_EDGE);
                ST_FOUND:    state_d = !arm_i ? ST_FROZEN : ST_FOUND;
                ST_FROZEN:   state_d = arm_i ? ST_ARMED : ST_FROZEN;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_n_o <= 1'b0;
        else if (wipe_i)
            flag_n_o <= 1'b1;
        else if (state_q == ST_ONE_EDGE && state_d == ST_FOUND)
            flag_n_o <= 1'b0;
    end

    // R2: wipe forces the absent value
    a_r2_wipe_forces: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_i |=> flag_n_o);

    // R4: a detection needs a counted transition while armed
    a_r4_fall_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_n_o) |-> $past(edge_i && arm_i && !mode_i));

    // R5: a frozen result does not move
    a_r5_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN && !wipe_i && !arm_i) |=> $stable(flag_n_o));

    // R7: no detection while the controller owns the pin
    a_r7_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |=> !$fell(flag_n_o));

endmodule

// File: rtl/bclk_sense_top.sv
module bclk_sense_top
    import bclk_det_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_HALF    = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [CTRL_W-1:0] bus_wdata,
    output logic [CTRL_W-1:0] bus_rdata,
    input  logic              bclk_in,
    output logic              bclk_out,
    output logic              bclk_oe
);

    logic sys_rst_n;
    logic wipe, arm, mode, flag_n, pin_edge;

    assign sys_rst_n = rst_n & por_n;

    bclk_ctrl_reg u_reg (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .wr_i      (bus_wr),
        .wdata_i   (bus_wdata),
        .flag_n_i  (flag_n),
        .wipe_o    (wipe),
        .arm_o     (arm),
        .mode_o    (mode),
        .rdata_o   (bus_rdata)
    );

    bclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .async_i (bclk_in),
        .edge_o  (pin_edge)
    );

    bclk_det_fsm u_fsm (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .wipe_i   (wipe),
        .arm_i    (arm),
        .mode_i   (mode),
        .edge_i   (pin_edge),
        .flag_n_o (flag_n)
    );

    bclk_clkgen #(.DIV_HALF(DIV_HALF)) u_gen (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .mode_i (mode),
        .bclk_o (bclk_out)
    );

    assign bclk_oe = mode;

endmodule

// File: tb/bclk_sense_top_test.sv
module bclk_sense_top_test;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bclk_in = 1'b0;
    logic       bclk_out;
    logic       bclk_oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bclk_sense_top uut (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bclk_in   (bclk_in),
        .bclk_out  (bclk_out),
        .bclk_oe   (bclk_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic toggle_pin();
        bclk_in = ~bclk_in;
        settle(4);
    endtask

    task automatic t_reset_state();
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 oe", bclk_oe, 0);
        check("R1 out", bclk_out, 0);
    endtask

    task automatic t_wipe_holds();
        reg_write(8'h08);
        settle(1);
        check("R2 flag after wipe", bus_rdata[1], 1);
        reg_write(8'h0C);
        repeat (3) toggle_pin();
        check("R2 flag held", bus_rdata[1], 1);
        check("R2 rdata", bus_rdata, 8'h0E);
    endtask

    task automatic t_idle_ignores();
        reg_write(8'h00);
        repeat (3) toggle_pin();
        check("R3 idle flag", bus_rdata[1], 1);
    endtask

    task automatic t_detect();
        reg_write(8'h04);
        toggle_pin();
        check("R4 one transition", bus_rdata[1], 1);
        toggle_pin();
        check("R4 two transitions", bus_rdata[1], 0);
    endtask

    task automatic t_freeze_rearm();
        reg_write(8'h08);
        reg_write(8'h04);
        toggle_pin();
        reg_write(8'h00);
        repeat (3) toggle_pin();
        check("R5 frozen", bus_rdata[1], 1);
        reg_write(8'h04);
        toggle_pin();
        check("R5 rearm restarts count", bus_rdata[1], 1);
        toggle_pin();
        check("R5 rearm detects", bus_rdata[1], 0);
    endtask

    // pin flips now; the write arrives after 'gap' negedges
    task automatic t_collide(input int gap, input logic [7:0] v);
        reg_write(8'h08);
        reg_write(8'h04);
        toggle_pin();
        bclk_in = ~bclk_in;
        settle(gap);
        bus_wr = 1'b1;
        bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
        settle(3);
    endtask

    task automatic t_collisions();
        t_collide(1, 8'h00);
        check("R6 freeze same cycle", bus_rdata[1], 1);
        t_collide(2, 8'h00);
        check("R6 freeze one late", bus_rdata[1], 0);
        t_collide(1, 8'h0C);
        check("R6 wipe wins", bus_rdata[1], 1);
        reg_write(8'h04);
        settle(3);
        check("R6 after wipe release", bus_rdata[1], 1);
    endtask

    task automatic t_drive_mode();
        int first;
        int span;
        logic last;
        reg_write(8'h08);
        reg_write(8'h05);
        repeat (3) toggle_pin();
        check("R7 mode1 ignores pin", bus_rdata[1], 1);
        check("R8 oe in mode1", bclk_oe, 1);
        last = bclk_out;
        first = 0;
        while (bclk_out == last && first < 20) begin
            settle(1);
            first++;
        end
        last = bclk_out;
        span = 0;
        while (bclk_out == last && span < 20) begin
            settle(1);
            span++;
        end
        check("R8 half period", span, 4);
        reg_write(8'h04);
        settle(1);
        check("R8 oe in mode0", bclk_oe, 0);
        check("R8 out parked", bclk_out, 0);
    endtask

    task automatic t_reserved();
        reg_write(8'hF1);
        settle(1);
        check("R10 reserved and flag", bus_rdata, 8'h03);
    endtask

    task automatic t_resets();
        @(negedge clk);
        rst_n = 1'b0;
        settle(3);
        rst_n = 1'b1;
        settle(1);
        check("R9 mode kept", bus_rdata, 8'h01);
        por_n = 1'b0;
        settle(3);
        por_n = 1'b1;
        settle(1);
        check("R9 por clears", bus_rdata, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        settle(4);
        por_n = 1'b1;
        rst_n = 1'b1;
        settle(2);
        t_reset_state();
        t_wipe_holds();
        t_idle_ignores();
        t_detect();
        t_freeze_rearm();
        t_collisions();
        t_drive_mode();
        t_reserved();
        t_resets();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule